// File: doc/BRIEF.md
# Serial Debug Port Controller

This block links an external debug tool to a processor core that is halted in debug mode. A tool-facing serial line feeds one shift register, and a second line drives data back out of it. That same register also backs two core-side pseudo-registers. The core fetches its debug-mode instructions from one of them. It moves data to and from the tool through the other. Each frame the tool sends gets a reply frame of equal length, shifted out at the same time. The reply carries a 2-bit status and a 32-bit word.

A frame is tagged either as a core transfer or as a control transfer. A control transfer loads a 9-bit control register. That register drives six trap-enable lines, two breakpoint lines and a video-sync line to the core, and the core has no access path to it. Shifting runs in one of two modes:

- **Synchronous mode:** the tool times its bits to the system clock, and the port shifts once per clock.
- **Asynchronous mode:** the tool supplies its own serial clock. That clock and the data pin are resynchronised, and the port shifts on each detected rising edge.

When the core asks for one kind of transfer but the tool sent the other kind, the port drops the word. It then reports a sequence error in its next reply.

Top module: `dbg_serial_port`

## Requirements
- R1: After reset, all nine control outputs are 0, `core_ready` is low while no request is made, and `sdo` is 0.
- R2: A frame on `sdi` has the following layout, and it is accepted only while the port is idle:
  - a start bit of 1;
  - a type bit (0 = core transfer, 1 = control transfer);
  - a kind bit (1 = instruction, 0 = data);
  - 32 payload bits, most significant bit first.

  With `sync_mode` = 1, one bit is taken on every rising edge of `clk`.
- R3: With `sync_mode` = 0, one bit is taken on each rising edge of `sck`, after both `sck` and `sdi` have passed through a two-flop synchroniser. The frame format is the same as in R2.
- R4: A control transfer loads payload bits [8:0] into the control register and ignores the upper payload bits. Bit [8] drives `vsync`, bits [7:6] drive `bkpt`, and bits [5:0] drive `trap_en`. The outputs hold their value until the next control transfer, and core transfers leave them unchanged.
- R5: A core read stalls with `core_ready` low until a core-transfer frame has been received. The read operations are `core_op` = 00 (instruction fetch) and `core_op` = 01 (data read).
- R6: Both read operations are served by the same received word. A fetch completes on an instruction-kind frame, and a data read completes on a data-kind frame. On completion, `core_ready` is high for the request cycle and `core_rdata` holds the payload.
- R7: A core write (`core_op` = 10) is acknowledged in the same cycle. Its data becomes the payload of the next reply, sent with status 00. The op code 11 is never acknowledged.
- R8: A read that finds a received word of the wrong kind has the following effects:
  - the word is discarded and `core_ready` stays low;
  - the next reply carries status 01 with a zero payload;
  - any pending write data is held back for the reply after that one.
- R9: With no pending error and no pending write, a reply carries status 11 and a zero payload. In every reply the status goes out first, most significant bit first, during the type and kind bit slots.
- R10: A control transfer does not satisfy a pending core read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 = shift on every clock, 0 = shift on the external serial clock |
| sck | input | 1 | Serial clock from the tool (asynchronous mode) |
| sdi | input | 1 | Serial data from the tool |
| sdo | output | 1 | Serial reply data to the tool |
| core_req | input | 1 | Core access request |
| core_op | input | 2 | 00 fetch instruction, 01 read data, 10 write data |
| core_wdata | input | 32 | Core write data |
| core_rdata | output | 32 | Word received from the tool |
| core_ready | output | 1 | Access completes this cycle |
| trap_en | output | 6 | Trap-enable lines |
| bkpt | output | 2 | Breakpoint lines |
| vsync | output | 1 | Video-sync line |

## Verification
The bench targets four corner cases:

- **Kind mismatch.** The core asks for data but an instruction word arrives. A design that handed the word over anyway would raise `core_ready`, and one that never flagged the error would reply 11 or 00 instead of 01.
- **Error and write pending together.** A sequence error and a pending write exist at the same time. A design with the wrong priority would send the data first, or would lose the data altogether.
- **Control frame during a stalled read, and upper payload bits.** A control frame arrives while a read is stalled, and control frames arrive with their upper payload bits set. A design that mixed up the two paths would release the read, change the control lines on core frames, or leak high bits into them.
- **Mode and bit order.** Both clock modes are run with random payloads. A design with a misaligned synchroniser, or with the bit order reversed, would shift every word by a bit.

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int DATA_W = 32,
  parameter int TRAP_W = 6,
  parameter int BKPT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  input  logic              core_req,
  input  logic [1:0]        core_op,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_ready,
  output logic [TRAP_W-1:0] trap_en,
  output logic [BKPT_W-1:0] bkpt,
  output logic              vsync
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int CTRL_W  = TRAP_W + BKPT_W + 1;

  localparam logic [1:0] OP_FETCH = 2'b00;
  localparam logic [1:0] OP_RDATA = 2'b01;
  localparam logic [1:0] OP_WDATA = 2'b10;

  logic [2:0] sck_q;
  logic [1:0] sdi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      sdi_q <= {sdi_q[0], sdi};
    end

  logic sck_rise, ev, din;
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign ev  = sync_mode ? 1'b1 : sck_rise;
  assign din = sync_mode ? sdi : sdi_q[1];

  logic               busy;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sr;
  logic               seq_err, tx_valid;
  logic [DATA_W-1:0]  tx_data;
  logic               rx_full, rx_instr;
  logic [DATA_W-1:0]  rx_word;
  logic [CTRL_W-1:0]  ctrl_q;

  logic start, shift, done;
  assign start = ~busy & ev & din;
  assign shift = busy & ev;
  assign done  = shift && (cnt == CNT_W'(FRAME_W - 1));

  logic [FRAME_W-1:0] nxt;
  assign nxt = {sr[FRAME_W-2:0], din};

  logic [1:0]        st_out;
  logic [DATA_W-1:0] tx_out;
  assign st_out = seq_err ? 2'b01 : (tx_valid ? 2'b00 : 2'b11);
  assign tx_out = (seq_err | ~tx_valid) ? '0 : tx_data;

  logic rd, want_instr, rd_hit, rd_miss, wr;
  assign rd         = core_req & (core_op == OP_FETCH | core_op == OP_RDATA);
  assign want_instr = (core_op == OP_FETCH);
  assign rd_hit     = rd & rx_full & (rx_instr == want_instr);
  assign rd_miss    = rd & rx_full & (rx_instr != want_instr);
  assign wr         = core_req & (core_op == OP_WDATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sr   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      sr   <= {st_out, tx_out};
    end else if (shift) begin
      sr  <= nxt;
      cnt <= cnt + 1'b1;
      if (done) busy <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             ctrl_q <= '0;
    else if (done && nxt[FRAME_W-1])        ctrl_q <= nxt[CTRL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_full  <= 1'b0;
      rx_instr <= 1'b0;
      rx_word  <= '0;
    end else if (done && !nxt[FRAME_W-1]) begin
      rx_full  <= 1'b1;
      rx_instr <= nxt[FRAME_W-2];
      rx_word  <= nxt[DATA_W-1:0];
    end else if (rd_hit | rd_miss) begin
      rx_full  <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       seq_err <= 1'b0;
    else if (rd_miss) seq_err <= 1'b1;
    else if (start)   seq_err <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (wr) begin
      tx_valid <= 1'b1;
      tx_data  <= core_wdata;
    end else if (start && !seq_err) begin
      tx_valid <= 1'b0;
    end

  assign sdo        = sr[FRAME_W-1];
  assign core_rdata = rx_word;
  assign core_ready = rd_hit | wr;
  assign trap_en    = ctrl_q[TRAP_W-1:0];
  assign bkpt       = ctrl_q[TRAP_W+BKPT_W-1:TRAP_W];
  assign vsync      = ctrl_q[CTRL_W-1];
endmodule

module dbg_serial_port_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          start,
  input logic          seq_err,
  input logic          tx_valid,
  input logic          rx_full,
  input logic          core_req,
  input logic [1:0]    core_op,
  input logic          core_ready,
  input logic [1:0]    sr_top,
  input logic [CW-1:0] ctrl_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ctrl_out == '0);

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(ctrl_out));

  // R5
  read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && core_op != 2'b10 && !rx_full) |-> !core_ready);

  // R7
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && core_op == 2'b10) |-> core_ready);

  // R8
  seq_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && seq_err) |=> sr_top == 2'b01);

  // R9
  null_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !seq_err && !tx_valid) |=> sr_top == 2'b11);
endmodule

bind dbg_serial_port dbg_serial_port_chk #(.CW(TRAP_W + BKPT_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .seq_err(seq_err),
  .tx_valid(tx_valid), .rx_full(rx_full), .core_req(core_req), .core_op(core_op),
  .core_ready(core_ready), .sr_top(sr[DATA_W+1:DATA_W]), .ctrl_out({vsync, bkpt, trap_en})
);

// File: tb/sim_dbg_serial_port.sv
module sim_dbg_serial_port;
  logic clk = 0, rst_n = 0, sync_mode = 1, sck = 0, sdi = 0;
  logic core_req = 0;
  logic [1:0] core_op = 0;
  logic [31:0] core_wdata = 0;
  logic sdo, core_ready, vsync;
  logic [31:0] core_rdata;
  logic [5:0] trap_en;
  logic [1:0] bkpt;

  always #4 clk = ~clk;

  dbg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sck(sck), .sdi(sdi), .sdo(sdo),
    .core_req(core_req), .core_op(core_op), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_ready(core_ready),
    .trap_en(trap_en), .bkpt(bkpt), .vsync(vsync)
  );

  int checks = 0, fails = 0;
  logic [8:0]  m_ctrl = 0;
  logic        m_pend = 0, m_serr = 0, m_full = 0, m_instr = 0;
  logic [31:0] m_pdata = 0, m_rx = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    if (sync_mode) begin
      @(negedge clk); sdi = b;
    end else begin
      sdi = b;
      repeat (2) @(negedge clk);
      sck = 1;
      repeat (4) @(negedge clk);
      sck = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  function automatic logic [33:0] reply_model();
    if (m_serr)      return {2'b01, 32'h0};
    else if (m_pend) return {2'b00, m_pdata};
    else             return {2'b11, 32'h0};
  endfunction

  task automatic frame(input logic ctl, input logic instr, input logic [31:0] pay, input string req);
    logic [33:0] fr, got, exp;
    fr  = {ctl, instr, pay};
    exp = reply_model();
    if (m_serr) m_serr = 0; else m_pend = 0;
    if (!sync_mode) @(negedge clk);
    put_bit(1'b1);
    for (int i = 33; i >= 0; i--) begin
      if (sync_mode) begin
        @(negedge clk); got[i] = sdo; sdi = fr[i];
      end else begin
        got[i] = sdo; put_bit(fr[i]);
      end
    end
    if (sync_mode) @(negedge clk);
    sdi = 0;
    @(negedge clk);
    check(req, {30'h0, got}, {30'h0, exp});
    if (ctl) m_ctrl = pay[8:0];
    else begin m_full = 1; m_instr = instr; m_rx = pay; end
    check("R4", {55'h0, vsync, bkpt, trap_en}, {55'h0, m_ctrl});
  endtask

  task automatic core_write(input logic [31:0] d);
    @(negedge clk); core_req = 1; core_op = 2'b10; core_wdata = d;
    #1 check("R7", {63'h0, core_ready}, 64'h1);
    @(negedge clk); core_req = 0;
    m_pend = 1; m_pdata = d;
  endtask

  task automatic core_read(input logic [1:0] op, input string req);
    logic hit;
    hit = m_full && (m_instr == (op == 2'b00));
    @(negedge clk); core_req = 1; core_op = op;
    #1 check(req, {63'h0, core_ready}, {63'h0, hit});
    if (hit) check("R2", {32'h0, core_rdata}, {32'h0, m_rx});
    @(negedge clk); core_req = 0;
    if (m_full && !hit) m_serr = 1;
    m_full = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    check("R1", {55'h0, vsync, bkpt, trap_en}, 64'h0);
    check("R1", {62'h0, core_ready, sdo}, 64'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    core_read(2'b01, "R5 stall with no frame");
    frame(1'b1, 1'b0, 32'hFFFF_FE5A, "R9 null reply");
    core_read(2'b00, "R10 control frame does not release read");
    core_write(32'hCAFE_1234);
    frame(1'b0, 1'b1, 32'h8000_0001, "R7 write reply");
    core_read(2'b00, "R6 fetch on instruction frame");
    frame(1'b0, 1'b0, 32'h1357_9BDF, "R9 reply after drain");
    core_read(2'b01, "R6 data read on data frame");
    core_write(32'h0BAD_F00D);
    frame(1'b0, 1'b1, 32'h2222_4444, "R7 reply");
    core_write(32'h7777_0001);
    core_read(2'b01, "R8 mismatch stalls");
    core_read(2'b01, "R8 word discarded");
    frame(1'b1, 1'b0, 32'h0000_01FF, "R8 error first");
    frame(1'b1, 1'b0, 32'h0000_0100, "R8 data after error");
    core_read(2'b11, "R7 op 11 ignored");

    for (int k = 0; k < 40; k++) begin
      case ($urandom % 4)
        0: core_write($urandom);
        1: frame(1'b1, 1'($urandom), $urandom, "R2 random control");
        2: frame(1'b0, 1'($urandom), $urandom, "R2 random core");
        default: core_read(2'($urandom % 2), "R6 random read");
      endcase
    end

    core_read(2'b00, "R6 drain");
    sync_mode = 0;
    repeat (4) @(negedge clk);
    frame(1'b1, 1'b0, 32'h0000_0AA5, "R3 async control");
    core_write(32'hA5A5_3C3C);
    frame(1'b0, 1'b0, 32'h9ABC_DEF0, "R3 async write reply");
    core_read(2'b01, "R3 async data read");
    for (int k = 0; k < 4; k++)
      frame(1'($urandom), 1'($urandom), $urandom, "R3 async random");
    core_read(2'b00, "R3 async read");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule